// File: doc/BRIEF.md
# Serial Memory Slave Front End

This block is the serial front end of a byte-wide memory. It acts as a slave on a four-wire serial bus (clock, data in, data out, active-low select) and also takes an active-low pause input. A frame opens with an opcode byte. Memory opcodes follow it with a 16-bit address, most significant bit first, and then data bytes. Read data and status are returned on the serial output. Bytes for the array are collected in a page buffer and committed only when the frame closes cleanly. A parameterized cycle counter stands in for the self-timed programming period.

The serial inputs are oversampled by the system clock through synchronizers. The serial output drives a data bit and a separate enable, and the enable is what floats the pin. A separate protection unit decides whether array and configuration writes are permitted, and it tells the block through the `wr_allow` input. The array depth is set by `ARRAY_AW`. The default of 11 keeps elaboration small, and 14 gives the full 16K x 8 array.

Top module: `spi_mem_slave`

## Requirements
- R1: Data on `si` is taken on each rising `sck` edge, and `so` moves to the next bit after each falling edge. Bytes travel most significant bit first. This works the same whether `sck` idles low (mode 0) or high (mode 3).
- R2: `so_en` is low whenever the block is deselected, unarmed or paused, and high while it is selected and armed.
- R3: After reset the block takes no action on any frame until `cs_n` has been seen to go from high to low.
- R4: Raising `cs_n` discards a partly shifted byte or command, and that frame has no effect.
- R5: While selected with `hold_n` low, `sck` and `si` are ignored and the shift position is kept. When `hold_n` returns high the frame continues from the same bit.
- R6: Opcode 0x06 sets the write-enable flag and 0x04 clears it. Opcode 0x05 returns the status byte repeatedly: bits 7..2 hold the configuration field, bit 1 the write-enable flag and bit 0 busy.
- R7: Opcode 0x03 followed by a 16-bit address returns bytes from consecutive addresses. Only the low `ARRAY_AW` address bits are used, and the address wraps from the top of the array to 0.
- R8: Opcode 0x02 followed by a 16-bit address buffers data bytes. The low 5 address bits advance and wrap inside the 32-byte page. The page is written only if `cs_n` rises after at least one whole data byte, with write enable set, `wr_allow` high and busy clear. Otherwise the array is unchanged.
- R9: A committed page write sets busy for `WR_CYCLES` clocks and clears write enable. While busy, WRITE and WRSR opcodes are refused.
- R10: Opcode 0x01 followed by a byte loads data bits 7..2 into the configuration field when `cs_n` rises, under the same write-enable and `wr_allow` conditions, and then clears write enable.
- R11: An unrecognised opcode makes the block ignore the rest of the frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the serial lines |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low select |
| sck | input | 1 | Serial clock |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Active-low pause |
| wr_allow | input | 1 | High when the protection unit permits writes |
| so | output | 1 | Serial data out |
| so_en | output | 1 | Output enable for `so`; low means floating |
| (none) | | | |

## Verification
The assertions assume that `sck` stays at least a few system clocks in each level, so that every serial edge is seen once after synchronization. They also assume that `hold_n` changes only while `sck` is low, and that `cs_n` changes only between bits. The bench drives every serial line on the falling edge of the system clock. It holds each `sck` phase for eight clocks, pauses only with `sck` low, and raises `cs_n` only after a full bit time. Random choices of page, column, length, data and clock mode stay inside those limits.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;
   typedef enum logic [2:0] {PH_OPC, PH_AHI, PH_ALO, PH_DAT, PH_IGN} phase_e;
   localparam logic [7:0] OP_WRSR  = 8'h01;
   localparam logic [7:0] OP_WRITE = 8'h02;
   localparam logic [7:0] OP_READ  = 8'h03;
   localparam logic [7:0] OP_WRDI  = 8'h04;
   localparam logic [7:0] OP_RDSR  = 8'h05;
   localparam logic [7:0] OP_WREN  = 8'h06;
endpackage

// File: rtl/spi_mem_sync.sv
module spi_mem_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [STAGES-1:0] r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               r <= {STAGES{RST_VAL}};
            end else begin
               r[0] <= d;
               for (int i = 1; i < STAGES; i++) r[i] <= r[i-1];
            end
         end
         assign q = r[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/spi_mem_wtimer.sv
module spi_mem_wtimer #(
   parameter int CYC = 64
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   start,
   output logic                   busy,
   output logic [$clog2(CYC)-1:0] idx
);
   localparam int TW = $clog2(CYC);
   logic [TW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         cnt  <= '0;
      end else if (start) begin
         busy <= 1'b1;
         cnt  <= '0;
      end else if (busy) begin
         if (cnt == TW'(CYC - 1)) busy <= 1'b0;
         else                     cnt  <= cnt + TW'(1);
      end
   end
   assign idx = cnt;

   AST_NO_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> !busy); // R9
   AST_BUSY_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> ($past(cnt) == TW'(CYC - 1))); // R9
endmodule

// File: rtl/spi_mem_array.sv
module spi_mem_array #(
   parameter int AW = 11,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);
   localparam int DEPTH = 1 << AW;
   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
      rdata <= mem[raddr];
   end
endmodule

// File: rtl/spi_mem_ctrl.sv
module spi_mem_ctrl import spi_mem_pkg::*; #(
   parameter int AW = 11,
   parameter int CB = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cs_s,
   input  logic             sck_s,
   input  logic             si_s,
   input  logic             hold_s,
   input  logic             wr_allow,
   input  logic             busy,
   input  logic [7:0]       rdata,
   output logic [AW-1:0]    raddr,
   output logic             so,
   output logic             so_en,
   output logic             commit,
   output logic [AW-CB-1:0] cpage,
   input  logic [CB-1:0]    bidx,
   output logic [7:0]       bbyte,
   output logic             bval
);
   localparam int NB = 1 << CB;

   phase_e        phase;
   logic [7:0]    opc, ahi, tx;
   logic [6:0]    sh;
   logic [5:0]    cfg, cfg_n;
   logic [2:0]    bitcnt;
   logic [AW-1:0] addr;
   logic          wel, armed, cs_q, sck_q, ld1, ld2, got, so_q;
   logic [7:0]    pbuf [NB];
   logic [NB-1:0] pval;

   logic sel, held, active, cs_fall, cs_rise, sck_rise, sck_fall, byte_done;
   logic do_wsr, out_ph, pb_we;
   logic [7:0]    byte_in, status;
   logic [15:0]   full_a;
   logic [CB-1:0] col_nx;

   assign cs_fall   = cs_q & ~cs_s;
   assign cs_rise   = ~cs_q & cs_s;
   assign sel       = armed & ~cs_s;
   assign held      = sel & ~hold_s;
   assign active    = sel & hold_s;
   assign sck_rise  = active & ~sck_q & sck_s;
   assign sck_fall  = active & sck_q & ~sck_s;
   assign byte_in   = {sh, si_s};
   assign byte_done = sck_rise & (bitcnt == 3'd7);
   assign full_a    = {ahi, byte_in};
   assign col_nx    = addr[CB-1:0] + CB'(1);
   assign status    = {cfg, wel, busy};
   assign out_ph    = (phase == PH_DAT) & ((opc == OP_READ) | (opc == OP_RDSR));
   assign pb_we     = byte_done & (phase == PH_DAT) & (opc == OP_WRITE);
   assign commit    = cs_rise & armed & (phase == PH_DAT) & (opc == OP_WRITE)
                    & (bitcnt == 3'd0) & got & wel & ~busy & wr_allow;
   assign do_wsr    = cs_rise & armed & (phase == PH_DAT) & (opc == OP_WRSR)
                    & (bitcnt == 3'd0) & got & wel & ~busy & wr_allow;

   always_ff @(posedge clk) begin
      if (pb_we) pbuf[addr[CB-1:0]] <= byte_in;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_OPC;  opc <= '0;   ahi <= '0;  tx <= '0;  sh <= '0;
         cfg <= '0;  cfg_n <= '0;  bitcnt <= '0;  addr <= '0;  wel <= 1'b0;
         armed <= 1'b0;  cs_q <= 1'b0;  sck_q <= 1'b0;  ld1 <= 1'b0;
         ld2 <= 1'b0;  got <= 1'b0;  so_q <= 1'b0;  pval <= '0;  cpage <= '0;
      end else begin
         cs_q  <= cs_s;
         sck_q <= sck_s;
         ld1   <= 1'b0;
         ld2   <= ld1;
         if (cs_fall) armed <= 1'b1;
         if (ld2) tx <= (opc == OP_RDSR) ? status : rdata;
         if (cs_rise) begin
            phase  <= PH_OPC;
            bitcnt <= '0;
            got    <= 1'b0;
            ld2    <= 1'b0;
            if (commit) begin
               wel   <= 1'b0;
               cpage <= addr[AW-1:CB];
            end
            if (do_wsr) begin
               wel <= 1'b0;
               cfg <= cfg_n;
            end
         end else if (sck_rise) begin
            sh     <= byte_in[6:0];
            bitcnt <= bitcnt + 3'd1;
            if (bitcnt == 3'd7) begin
               case (phase)
                  PH_OPC: begin
                     opc   <= byte_in;
                     phase <= PH_IGN;
                     case (byte_in)
                        OP_WREN:  wel <= 1'b1;
                        OP_WRDI:  wel <= 1'b0;
                        OP_RDSR:  begin phase <= PH_DAT; ld1 <= 1'b1; end
                        OP_READ:  phase <= PH_AHI;
                        OP_WRITE: if (!busy) begin phase <= PH_AHI; pval <= '0; end
                        OP_WRSR:  if (!busy) phase <= PH_DAT;
                        default:  ;
                     endcase
                  end
                  PH_AHI: begin ahi <= byte_in; phase <= PH_ALO; end
                  PH_ALO: begin
                     addr  <= AW'(full_a);
                     phase <= PH_DAT;
                     if (opc == OP_READ) ld1 <= 1'b1;
                  end
                  PH_DAT: begin
                     case (opc)
                        OP_READ:  begin addr <= addr + AW'(1); ld1 <= 1'b1; end
                        OP_RDSR:  ld1 <= 1'b1;
                        OP_WRITE: begin
                           pval[addr[CB-1:0]] <= 1'b1;
                           addr[CB-1:0]       <= col_nx;
                           got                <= 1'b1;
                        end
                        OP_WRSR:  begin cfg_n <= byte_in[7:2]; got <= 1'b1; end
                        default:  ;
                     endcase
                  end
                  default: ;
               endcase
            end
         end else if (sck_fall && out_ph) begin
            so_q <= tx[7];
            tx   <= {tx[6:0], 1'b0};
         end
      end
   end

   assign raddr = addr;
   assign so    = so_q;
   assign so_en = active;
   assign bbyte = pbuf[bidx];
   assign bval  = pval[bidx];

   AST_QUIET_UNARMED: assert property (@(posedge clk) disable iff (!rst_n)
      !armed |-> (phase == PH_OPC) && (bitcnt == 3'd0) && !wel); // R3
   AST_HOLD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      held && $past(held) |-> $stable(bitcnt) && $stable(sh) && $stable(phase)); // R5
   AST_COMMIT_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      commit |-> ($countones(pval) != 0)); // R8
   AST_WEL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> !wel); // R9
endmodule

// File: rtl/spi_mem_slave.sv
module spi_mem_slave #(
   parameter int ARRAY_AW    = 11,
   parameter int PAGE_BYTES  = 32,
   parameter int WR_CYCLES   = 200,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_n,
   input  logic sck,
   input  logic si,
   input  logic hold_n,
   input  logic wr_allow,
   output logic so,
   output logic so_en
);
   localparam int CB = $clog2(PAGE_BYTES);
   localparam int PW = ARRAY_AW - CB;
   localparam int TW = $clog2(WR_CYCLES);

   generate
      if (PAGE_BYTES < 2 || (PAGE_BYTES & (PAGE_BYTES - 1)) != 0) begin : g_bad_page
         $error("PAGE_BYTES must be a power of two");
      end
      if (ARRAY_AW <= CB || ARRAY_AW > 16) begin : g_bad_aw
         $error("ARRAY_AW must exceed the page bits and fit 16 address bits");
      end
      if (WR_CYCLES < PAGE_BYTES) begin : g_bad_cyc
         $error("WR_CYCLES must cover one clock per page byte");
      end
      if (SYNC_STAGES < 0) begin : g_bad_sync
         $error("SYNC_STAGES must not be negative");
      end
   endgenerate

   logic cs_s, sck_s, si_s, hold_s;
   spi_mem_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_cs
      (.clk(clk), .rst_n(rst_n), .d(cs_n),   .q(cs_s));
   spi_mem_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sck
      (.clk(clk), .rst_n(rst_n), .d(sck),    .q(sck_s));
   spi_mem_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_si
      (.clk(clk), .rst_n(rst_n), .d(si),     .q(si_s));
   spi_mem_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_hold
      (.clk(clk), .rst_n(rst_n), .d(hold_n), .q(hold_s));

   logic                busy, commit, bval, mem_we;
   logic [TW-1:0]       idx;
   logic [PW-1:0]       cpage;
   logic [7:0]          bbyte, rdata;
   logic [ARRAY_AW-1:0] raddr;

   spi_mem_ctrl #(.AW(ARRAY_AW), .CB(CB)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .sck_s(sck_s), .si_s(si_s),
      .hold_s(hold_s), .wr_allow(wr_allow), .busy(busy), .rdata(rdata),
      .raddr(raddr), .so(so), .so_en(so_en), .commit(commit), .cpage(cpage),
      .bidx(idx[CB-1:0]), .bbyte(bbyte), .bval(bval));

   spi_mem_wtimer #(.CYC(WR_CYCLES)) u_tmr (
      .clk(clk), .rst_n(rst_n), .start(commit), .busy(busy), .idx(idx));

   assign mem_we = busy & ({1'b0, idx} < (TW+1)'(PAGE_BYTES)) & bval;

   spi_mem_array #(.AW(ARRAY_AW), .DW(8)) u_arr (
      .clk(clk), .we(mem_we), .waddr({cpage, idx[CB-1:0]}), .wdata(bbyte),
      .raddr(raddr), .rdata(rdata));
endmodule

// File: tb/spi_mem_slave_tb.sv
module spi_mem_slave_tb;
   localparam int CLK_P = 10;
   localparam int HALF  = 8;
   localparam int AW    = 11;

   logic clk = 1'b0;
   logic rst_n, cs_n, sck, si, hold_n, wr_allow, so, so_en;
   logic mode3 = 1'b0;
   int   n_chk = 0, n_fail = 0;
   bit   done = 1'b0;
   logic [7:0] mdl [2048];
   logic [7:0] wb  [64];
   logic [5:0] cfg_m = '0;
   logic [7:0] st;

   always #(CLK_P/2) clk = ~clk;

   spi_mem_slave #(.ARRAY_AW(AW), .PAGE_BYTES(32), .WR_CYCLES(600), .SYNC_STAGES(2)) u_dut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .hold_n(hold_n),
      .wr_allow(wr_allow), .so(so), .so_en(so_en));

   function automatic logic [7:0] stat_exp(input logic [5:0] c, input logic w, input logic b);
      return {c, w, b};
   endfunction
   function automatic logic [10:0] pg_addr(input logic [15:0] a, input int i);
      return {a[10:5], 5'(a[4:0] + 5'(i))};
   endfunction
   function automatic logic [10:0] rd_addr(input logic [15:0] a, input int i);
      return 11'(a + 16'(i));
   endfunction

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string rq);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %0h expected %0h", rq, act, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic xbits(input logic [7:0] t, input int nb, output logic [7:0] r);
      r = '0;
      for (int i = nb - 1; i >= 0; i--) begin
         if (mode3) sck = 1'b0;
         si = t[i];
         wait_clk(HALF);
         r[i] = so;
         sck = 1'b1;
         wait_clk(HALF);
         if (!mode3) sck = 1'b0;
      end
   endtask

   task automatic xfer(input logic [7:0] t, output logic [7:0] r);
      xbits(t, 8, r);
   endtask

   task automatic cs_low();
      sck = mode3;
      wait_clk(3);
      cs_n = 1'b0;
      wait_clk(4);
   endtask

   task automatic cs_high();
      wait_clk(4);
      cs_n = 1'b1;
      wait_clk(8);
   endtask

   task automatic cmd(input logic [7:0] op);
      logic [7:0] d;
      cs_low(); xfer(op, d); cs_high();
   endtask

   task automatic rdsr(output logic [7:0] s);
      logic [7:0] d;
      cs_low(); xfer(8'h05, d); xfer(8'h00, s); cs_high();
   endtask

   task automatic wr_frame(input logic [15:0] a, input int n);
      logic [7:0] d;
      cs_low();
      xfer(8'h02, d); xfer(a[15:8], d); xfer(a[7:0], d);
      for (int i = 0; i < n; i++) xfer(wb[i], d);
      cs_high();
   endtask

   task automatic mdl_write(input logic [15:0] a, input int n);
      for (int i = 0; i < n; i++) mdl[pg_addr(a, i)] = wb[i];
   endtask

   task automatic wait_idle();
      logic [7:0] s;
      s = 8'h01;
      for (int k = 0; k < 40; k++) begin
         rdsr(s);
         if (!s[0]) break;
      end
      chk(32'(s[0]), 0, "R9 busy clears");
   endtask

   task automatic full_write(input logic [15:0] a, input int n);
      logic [7:0] s;
      cmd(8'h06);
      wr_frame(a, n);
      mdl_write(a, n);
      rdsr(s);
      chk(32'(s), 32'(stat_exp(cfg_m, 1'b0, 1'b1)), "R9 busy set, enable cleared");
      wait_idle();
   endtask

   task automatic read_chk(input logic [15:0] a, input int n, input string rq);
      logic [7:0] d;
      cs_low();
      xfer(8'h03, d); xfer(a[15:8], d); xfer(a[7:0], d);
      for (int i = 0; i < n; i++) begin
         xfer(8'h00, d);
         chk(32'(d), 32'(mdl[rd_addr(a, i)]), rq);
      end
      cs_high();
   endtask

   task automatic fill_wb(input int n);
      for (int i = 0; i < n; i++) wb[i] = 8'($urandom);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      logic [7:0] d;
      int pg_list [4];
      void'($urandom(32'd1234));
      pg_list[0] = 0; pg_list[1] = 5; pg_list[2] = 9; pg_list[3] = 63;
      rst_n = 1'b0; cs_n = 1'b0; sck = 1'b0; si = 1'b0; hold_n = 1'b1; wr_allow = 1'b1;
      wait_clk(5);
      chk(32'(so_en), 0, "R2 reset output disabled");
      rst_n = 1'b1;
      wait_clk(5);

      // R3: select already low at reset, so the block stays unarmed
      xfer(8'h06, d);
      chk(32'(so_en), 0, "R3 unarmed output disabled");
      cs_high();
      rdsr(st);
      chk(32'(st), 32'(stat_exp(6'd0, 1'b0, 1'b0)), "R3 frame before first select ignored");

      // R6 enable flag set and clear
      cmd(8'h06); rdsr(st);
      chk(32'(st), 32'(stat_exp(6'd0, 1'b1, 1'b0)), "R6 set enable");
      cmd(8'h04); rdsr(st);
      chk(32'(st), 32'(stat_exp(6'd0, 1'b0, 1'b0)), "R6 clear enable");

      // R4 partial opcode aborted
      cs_low(); xbits(8'h06 >> 3, 5, d); cs_high();
      rdsr(st);
      chk(32'(st), 32'(stat_exp(6'd0, 1'b0, 1'b0)), "R4 partial opcode discarded");

      // R11 unknown opcode swallows the rest of the frame
      cs_low(); xfer(8'hAB, d); xfer(8'h06, d); cs_high();
      rdsr(st);
      chk(32'(st), 32'(stat_exp(6'd0, 1'b0, 1'b0)), "R11 unknown opcode ignored");

      // R10 config write refused without enable, then accepted
      cs_low(); xfer(8'h01, d); xfer(8'hFC, d); cs_high();
      rdsr(st);
      chk(32'(st), 32'(stat_exp(6'd0, 1'b0, 1'b0)), "R10 config write needs enable");
      cmd(8'h06);
      cs_low(); xfer(8'h01, d); xfer(8'hA9, d); cs_high();
      cfg_m = 6'h2A;
      rdsr(st);
      chk(32'(st), 32'(stat_exp(cfg_m, 1'b0, 1'b0)), "R10 config loaded, enable cleared");
      mode3 = 1'b1;
      rdsr(st);
      chk(32'(st), 32'(stat_exp(cfg_m, 1'b0, 1'b0)), "R1 status in mode 3");
      mode3 = 1'b0;

      // fill four pages
      foreach (pg_list[k]) begin
         fill_wb(32);
         full_write(16'({6'(pg_list[k]), 5'd0}), 32);
      end

      // R7 read across top of array with upper address bits set
      cs_low();
      chk(32'(so_en), 1, "R2 output enabled when selected");
      cs_high();
      chk(32'(so_en), 0, "R2 output disabled when deselected");
      read_chk(16'hF7FC, 8, "R7 read wraps top to zero");

      // R8 page wrap on a 40-byte write from column 12
      fill_wb(40);
      full_write(16'h00AC, 40);
      read_chk(16'h00A0, 32, "R8 column wraps inside page");

      // R8 refused: no enable
      fill_wb(4);
      wr_frame(16'h0000, 4);
      read_chk(16'h0000, 4, "R8 no enable leaves array");
      // R8 refused: protection denies
      cmd(8'h06);
      wr_allow = 1'b0;
      wr_frame(16'h0000, 4);
      wr_allow = 1'b1;
      read_chk(16'h0000, 4, "R8 denied write leaves array");
      // R8 refused: partial data byte
      cs_low();
      xfer(8'h02, d); xfer(8'h00, d); xfer(8'h00, d); xfer(8'h55, d); xbits(8'h0A, 4, d);
      cs_high();
      read_chk(16'h0000, 4, "R8 partial byte aborts write");
      cmd(8'h04);

      // R9 write during busy refused
      cmd(8'h06);
      fill_wb(4);
      wr_frame(16'h0120, 4);
      mdl_write(16'h0120, 4);
      cmd(8'h06);
      fill_wb(4);
      wr_frame(16'h0000, 4);
      wait_idle();
      cmd(8'h04);
      read_chk(16'h0000, 4, "R9 write while busy refused");
      read_chk(16'h0120, 4, "R9 first write committed");

      // R5 hold mid-address
      cs_low();
      xfer(8'h03, d); xfer(8'h00, d); xbits(8'h0A, 4, d);
      hold_n = 1'b0;
      wait_clk(4);
      chk(32'(so_en), 0, "R5 output floats during hold");
      for (int k = 0; k < 3; k++) begin
         si = 1'($urandom); sck = 1'b1; wait_clk(HALF);
         sck = 1'b0; wait_clk(HALF);
      end
      hold_n = 1'b1;
      wait_clk(4);
      xbits(8'h00, 4, d);
      for (int i = 0; i < 3; i++) begin
         xfer(8'h00, d);
         chk(32'(d), 32'(mdl[11'h0A0 + 11'(i)]), "R5 frame resumes after hold");
      end
      cs_high();

      // R1 read in mode 3
      mode3 = 1'b1;
      read_chk(16'h0130, 4, "R1 mode 3 read");
      mode3 = 1'b0;

      // random page writes
      for (int it = 0; it < 4; it++) begin
         int pg, col, n;
         pg  = pg_list[$urandom % 4];
         col = int'($urandom % 32);
         n   = 1 + int'($urandom % 40);
         mode3 = 1'($urandom);
         fill_wb(n);
         full_write(16'({5'($urandom), 6'(pg), 5'(col)}), n);
         read_chk(16'({6'(pg), 5'd0}), 32, "R8 random page write");
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule